// File: doc/BRIEF.md
# Write-Back Data Cache with Maintenance Commands

This block is a set-associative data cache that sits between one requesting core port and a simple line-wide memory port. Ordinary loads and stores are served from the cache. A store that misses first brings the line in from memory, and modified data goes back to memory only when the line leaves the cache or when a maintenance command cleans it.

The same core port also takes four maintenance commands:

- Drain the whole cache: every modified line is written back, then every line is dropped.
- Discard the whole cache: every line is dropped and no data is written back.
- Flush one line by address: the line is written back if it is modified, then evicted.
- Clean one line by address: the line is written back if it is modified and its modified mark is cleared. A parameter chooses whether the line then stays valid.

One request is in progress at a time. `busy` refuses new work until the request ends, and `done` pulses once when it ends. A whole-cache drain cannot be cut short by a new request.

Top module: `cwb_cache`

## Requirements
- R1: A load that hits returns the current word. A store that hits merges only the bytes enabled in `req_wstrb` (bit b covers bits 8b+7..8b of the word) and causes no memory transaction. The word is chosen by address bits 5..2.
- R2: A store miss fetches the line with exactly one memory read and does not write the store data to memory. The line is then held as modified.
- R3: Op 4 (drain all) writes back every modified line exactly once. It visits sets in ascending order and ways in ascending order within a set, and it issues no memory read. Clean or invalid lines use no transaction. Afterwards no line is valid and memory holds the last stored values.
- R4: Op 5 (discard all) makes no memory transaction and leaves no line valid, so stores not yet written back are lost.
- R5: Op 2 (flush line) writes a modified line back and then evicts it, so a later load refills it from memory. On a miss it makes no transaction and still completes.
- R6: Op 3 (clean line) writes a modified line back and clears its modified mark, so a second clean makes no transaction. With KEEP_ON_CLEAN=1 the line stays valid and a later load hits.
- R7: A miss takes the lowest invalid way first. With all ways valid it takes the tree pseudo-LRU way, and it writes that line back first if it is modified. Lines whose addresses are a multiple of 4 KiB apart share a set. When eight such lines are stored in order and a ninth is then stored, the first line is written back.
- R8: A request is accepted only when `req_valid` is high and `busy` is low. Op codes are 0 load, 1 store, 2 flush line, 3 clean line, 4 drain all, 5 discard all. `done` is a one-cycle pulse during which `busy` is already low. A request held during a drain is accepted only after the drain ends.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold steady. `mem_addr` is the byte address shifted right by 6.
- R10: After reset, `busy`, `done` and `mem_valid` are low and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_wstrb | input | 4 | Store byte enables |
| busy | output | 1 | Request in progress, new requests refused |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load data, valid with done |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_write | output | 1 | 1 write-back, 0 line fill |
| mem_addr | output | 26 | Line address |
| mem_wdata | output | 512 | Line being written back |
| mem_rdata | input | 512 | Line returned by a fill |

## Verification
Some properties are checked by assertions on every cycle. Requests to memory stay steady while they are stalled. `done` is a single-cycle pulse that never coincides with `busy`. No line is ever modified without also being valid. Memory traffic happens only while a request is in progress. Every line is invalid when either whole-cache command ends.

Other behaviour can only be shown by the directed scenarios, because it depends on what was stored earlier:
- the order in which a drain writes lines back;
- the choice of the pseudo-LRU victim;
- losing unsaved data after a discard;
- whether a clean retains or evicts its line;
- merging the enabled bytes into a stored word.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_FLUSH   = 3'd2,
    OP_CLEAN   = 3'd3,
    OP_DRAIN   = 3'd4,
    OP_DISCARD = 3'd5
  } cwb_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOKUP, S_HIT, S_WB_LOAD, S_WB_WAIT,
    S_FILL_REQ, S_FILL_WAIT, S_WALK, S_FINISH
  } cwb_state_e;

  typedef enum logic [1:0] {
    AFT_FILL, AFT_FLUSH, AFT_CLEAN, AFT_WALK
  } cwb_after_e;
endpackage

// File: rtl/cwb_plru.sv
module cwb_plru #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-2:0]         state_i,
  input  logic [$clog2(WAYS)-1:0] touch_i,
  output logic [$clog2(WAYS)-1:0] victim_o,
  output logic [WAYS-2:0]         next_o
);
  localparam int LVL = $clog2(WAYS);

  // Victim: walk the tree following the stored direction bits.
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < LVL; l++) begin
      node = node * 2 + int'(state_i[node-1]);
    end
    victim_o = LVL'(node - WAYS);
  end

  // Update: each node on the path now points away from the touched way.
  always_comb begin
    int node;
    next_o = state_i;
    node   = 1;
    for (int l = 0; l < LVL; l++) begin
      next_o[node-1] = ~touch_i[LVL-1-l];
      node = node * 2 + int'(touch_i[LVL-1-l]);
    end
  end
endmodule

// File: rtl/cwb_line_ram.sv
module cwb_line_ram #(
  parameter int WIDTH = 512,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int WAYS          = 8,
  parameter int SETS          = 64,
  parameter bit KEEP_ON_CLEAN = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  input  logic [2:0]                             req_op,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [WORD_W-1:0]                      req_wdata,
  input  logic [WORD_W/8-1:0]                    req_wstrb,
  output logic                                   busy,
  output logic                                   done,
  output logic [WORD_W-1:0]                      rdata,
  output logic                                   mem_valid,
  input  logic                                   mem_ready,
  output logic                                   mem_write,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_addr,
  output logic [LINE_BYTES*8-1:0]                mem_wdata,
  input  logic [LINE_BYTES*8-1:0]                mem_rdata
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENT_W   = IDX_W + WAY_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int BSTRB   = WORD_W / 8;
  localparam int BYTE_W  = $clog2(BSTRB);
  localparam int WSEL_W  = $clog2(LINE_W / WORD_W);

  cwb_state_e          state_q;
  cwb_op_e             op_q;
  cwb_after_e          after_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [BSTRB-1:0]    wstrb_q;
  logic [WAY_W-1:0]    way_q;
  logic [ENT_W-1:0]    wb_ent_q;
  logic [ENT_W-1:0]    walk_q;

  logic [TAG_W-1:0]    tag_q [ENTRIES];
  logic [ENTRIES-1:0]  valid_q;
  logic [ENTRIES-1:0]  dirty_q;
  logic [WAYS-2:0]     plru_q [SETS];

  // Decode of the latched address
  logic [IDX_W-1:0]    set_i;
  logic [TAG_W-1:0]    tag_i;
  logic [WSEL_W-1:0]   wsel_i;
  assign set_i  = addr_q[OFF_W +: IDX_W];
  assign tag_i  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel_i = addr_q[BYTE_W +: WSEL_W];

  // Tag compare and preferred invalid way (lowest index wins)
  logic             hit, inv_found;
  logic [WAY_W-1:0] hit_way, inv_way, plru_victim, victim_way;
  always_comb begin
    hit = 1'b0; hit_way = '0; inv_found = 1'b0; inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[{set_i, WAY_W'(w)}] && tag_q[{set_i, WAY_W'(w)}] == tag_i) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!valid_q[{set_i, WAY_W'(w)}]) begin
        inv_found = 1'b1; inv_way = WAY_W'(w);
      end
    end
  end

  logic [WAYS-2:0] plru_next;
  cwb_plru #(.WAYS(WAYS)) u_plru (
    .state_i (plru_q[set_i]),
    .touch_i (way_q),
    .victim_o(plru_victim),
    .next_o  (plru_next)
  );
  assign victim_way = inv_found ? inv_way : plru_victim;

  logic [ENT_W-1:0] hit_ent, vic_ent, cur_ent;
  assign hit_ent = {set_i, hit_way};
  assign vic_ent = {set_i, victim_way};
  assign cur_ent = {set_i, way_q};

  // Line storage: read in LOOKUP/WALK, data used from the next state on
  logic              ram_re, ram_we, fill_wr, store_wr;
  logic [ENT_W-1:0]  ram_raddr;
  logic [LINE_W-1:0] ram_q, merged, ram_wdata;
  assign ram_re    = (state_q == S_LOOKUP) || (state_q == S_WALK);
  assign ram_raddr = (state_q == S_WALK) ? walk_q : (hit ? hit_ent : vic_ent);
  assign fill_wr   = (state_q == S_FILL_WAIT) && mem_ready;
  assign store_wr  = (state_q == S_HIT) && (op_q == OP_STORE);
  assign ram_we    = fill_wr || store_wr;
  assign ram_wdata = fill_wr ? mem_rdata : merged;

  always_comb begin
    merged = ram_q;
    for (int b = 0; b < BSTRB; b++) begin
      if (wstrb_q[b]) merged[int'(wsel_i) * WORD_W + b * 8 +: 8] = wdata_q[b * 8 +: 8];
    end
  end

  cwb_line_ram #(.WIDTH(LINE_W), .DEPTH(ENTRIES)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(cur_ent),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .q    (ram_q)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      op_q      <= OP_LOAD;
      after_q   <= AFT_FILL;
      addr_q    <= '0;
      wdata_q   <= '0;
      wstrb_q   <= '0;
      way_q     <= '0;
      wb_ent_q  <= '0;
      walk_q    <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          op_q    <= cwb_op_e'(req_op);
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wstrb_q <= req_wstrb;
          busy    <= 1'b1;
          state_q <= S_LOOKUP;
        end
        S_LOOKUP: begin
          case (op_q)
            OP_LOAD, OP_STORE: begin
              if (hit) begin
                way_q   <= hit_way;
                state_q <= S_HIT;
              end else begin
                way_q    <= victim_way;
                wb_ent_q <= vic_ent;
                after_q  <= AFT_FILL;
                state_q  <= (valid_q[vic_ent] && dirty_q[vic_ent]) ? S_WB_LOAD : S_FILL_REQ;
              end
            end
            OP_FLUSH, OP_CLEAN: begin
              wb_ent_q <= hit_ent;
              after_q  <= (op_q == OP_FLUSH) ? AFT_FLUSH : AFT_CLEAN;
              if (hit && dirty_q[hit_ent]) state_q <= S_WB_LOAD;
              else begin
                if (hit && op_q == OP_FLUSH) valid_q[hit_ent] <= 1'b0;
                state_q <= S_FINISH;
              end
            end
            OP_DRAIN: begin
              walk_q  <= '0;
              state_q <= S_WALK;
            end
            OP_DISCARD: begin
              valid_q <= '0;
              dirty_q <= '0;
              state_q <= S_FINISH;
            end
            default: state_q <= S_FINISH;
          endcase
        end
        S_HIT: begin
          if (op_q == OP_STORE) dirty_q[cur_ent] <= 1'b1;
          else rdata <= ram_q[int'(wsel_i) * WORD_W +: WORD_W];
          plru_q[set_i] <= plru_next;
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= S_IDLE;
        end
        S_WALK: begin
          if (valid_q[walk_q] && dirty_q[walk_q]) begin
            wb_ent_q <= walk_q;
            after_q  <= AFT_WALK;
            state_q  <= S_WB_LOAD;
          end else begin
            valid_q[walk_q] <= 1'b0;
            if (&walk_q) state_q <= S_FINISH;
            else walk_q <= walk_q + 1'b1;
          end
        end
        S_WB_LOAD: begin
          mem_valid <= 1'b1;
          mem_write <= 1'b1;
          mem_addr  <= {tag_q[wb_ent_q], wb_ent_q[ENT_W-1:WAY_W]};
          mem_wdata <= ram_q;
          state_q   <= S_WB_WAIT;
        end
        S_WB_WAIT: if (mem_ready) begin
          mem_valid <= 1'b0;
          case (after_q)
            AFT_FILL: state_q <= S_FILL_REQ;
            AFT_FLUSH: begin
              valid_q[wb_ent_q] <= 1'b0;
              dirty_q[wb_ent_q] <= 1'b0;
              state_q <= S_FINISH;
            end
            AFT_CLEAN: begin
              dirty_q[wb_ent_q] <= 1'b0;
              if (!KEEP_ON_CLEAN) valid_q[wb_ent_q] <= 1'b0;
              state_q <= S_FINISH;
            end
            default: begin
              valid_q[wb_ent_q] <= 1'b0;
              dirty_q[wb_ent_q] <= 1'b0;
              if (&walk_q) state_q <= S_FINISH;
              else begin
                walk_q  <= walk_q + 1'b1;
                state_q <= S_WALK;
              end
            end
          endcase
        end
        S_FILL_REQ: begin
          mem_valid <= 1'b1;
          mem_write <= 1'b0;
          mem_addr  <= addr_q[ADDR_W-1:OFF_W];
          state_q   <= S_FILL_WAIT;
        end
        S_FILL_WAIT: if (mem_ready) begin
          mem_valid        <= 1'b0;
          tag_q[cur_ent]   <= tag_i;
          valid_q[cur_ent] <= 1'b1;
          dirty_q[cur_ent] <= 1'b0;
          state_q          <= S_LOOKUP;
        end
        S_FINISH: begin
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);

  // R6
  dirty_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (dirty_q & ~valid_q) == '0);

  // R3
  drain_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && busy && op_q == OP_DRAIN |-> mem_write);

  // R4
  all_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    done && (op_q == OP_DRAIN || op_q == OP_DISCARD) |-> valid_q == '0);
endmodule

// File: tb/cwb_cache_bench.sv
module cwb_cache_bench;
  localparam int LW = 512;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = '0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_wstrb = '0;
  logic         busy, done, mem_valid, mem_write;
  logic [31:0]  rdata;
  logic [25:0]  mem_addr;
  logic [LW-1:0] mem_wdata;
  logic         mem_ready = 1'b0;
  logic [LW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cwb_cache u_cwb_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .busy(busy), .done(done), .rdata(rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int hold_viol = 0, stall_seen = 0;
  logic [25:0] wb_log [64];
  logic [LW-1:0] model [logic [25:0]];

  function automatic logic [LW-1:0] get_line(input logic [25:0] la);
    logic [LW-1:0] l;
    if (model.exists(la)) return model[la];
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = ({la, 6'b0} + 32'(k * 4)) ^ 32'h5A5A_5A5A;
    return l;
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_5A5A;
  endfunction

  // Memory responder: ready after a fixed stall of several cycles
  int stall_cnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      stall_cnt <= 0;
    end else if (mem_valid && mem_ready) begin
      mem_ready <= 1'b0;
      stall_cnt <= 0;
      if (mem_write) begin
        model[mem_addr] = mem_wdata;
        wb_log[wr_cnt % 64] = mem_addr;
        wr_cnt++;
      end else rd_cnt++;
    end else if (mem_valid) begin
      if (stall_cnt == 2) begin
        mem_ready <= 1'b1;
        mem_rdata <= get_line(mem_addr);
      end else stall_cnt <= stall_cnt + 1;
    end
  end

  // R9 monitor at the falling edge
  logic pend = 1'b0;
  logic [25:0] p_addr;
  logic p_we;
  logic [LW-1:0] p_wd;
  always @(negedge clk) begin
    if (pend && (!mem_valid || mem_addr !== p_addr || mem_write !== p_we || mem_wdata !== p_wd))
      hold_viol++;
    pend   = !rst && mem_valid && !mem_ready;
    if (pend) stall_seen++;
    p_addr = mem_addr; p_we = mem_write; p_wd = mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] s, output logic [31:0] r);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    r = rdata;
  endtask

  logic [31:0] r;
  int rd0, wr0;

  task automatic t_reset;
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 mem_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_store_load;
    rd0 = rd_cnt; wr0 = wr_cnt;
    do_op(1, 32'h1008, 32'hDEAD_BEEF, 4'hF, r);
    chk("R2 fill count", rd_cnt - rd0, 1);
    chk("R10/R2 no write", wr_cnt - wr0, 0);
    do_op(0, 32'h1008, 0, 0, r);
    chk("R1 load hit", r, 32'hDEAD_BEEF);
    do_op(1, 32'h1008, 32'h0000_1234, 4'h3, r);
    do_op(0, 32'h1008, 0, 0, r);
    chk("R1 byte merge", r, 32'hDEAD_1234);
    do_op(0, 32'h100C, 0, 0, r);
    chk("R1 neighbour word", r, pat(32'h100C));
    chk("R1 hits no traffic", rd_cnt - rd0, 1);
  endtask

  task automatic t_flush;
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_op(2, 32'h1008, 0, 0, r);
    chk("R5 flush writes back", wr_cnt - wr0, 1);
    chk("R5 flush addr", 32'(wb_log[wr0 % 64]), 32'h40);
    do_op(0, 32'h1008, 0, 0, r);
    chk("R5 refill after evict", rd_cnt - rd0, 1);
    chk("R5 data kept in memory", r, 32'hDEAD_1234);
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_op(2, 32'h0009_0000, 0, 0, r);
    chk("R5 miss no traffic", (wr_cnt - wr0) + (rd_cnt - rd0), 0);
  endtask

  task automatic t_clean;
    do_op(1, 32'h1008, 32'h1111_2222, 4'hF, r);
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_op(3, 32'h1008, 0, 0, r);
    chk("R6 clean writes back", wr_cnt - wr0, 1);
    do_op(3, 32'h1008, 0, 0, r);
    chk("R6 second clean silent", wr_cnt - wr0, 1);
    do_op(0, 32'h1008, 0, 0, r);
    chk("R6 line retained", rd_cnt - rd0, 0);
    chk("R6 data", r, 32'h1111_2222);
  endtask

  task automatic t_discard;
    do_op(1, 32'h1008, 32'h3333_4444, 4'hF, r);
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_op(5, 0, 0, 0, r);
    chk("R4 no traffic", (wr_cnt - wr0) + (rd_cnt - rd0), 0);
    do_op(0, 32'h1008, 0, 0, r);
    chk("R4 refill", rd_cnt - rd0, 1);
    chk("R4 unsaved store lost", r, 32'h1111_2222);
  endtask

  task automatic t_conflict;
    do_op(5, 0, 0, 0, r);
    wr0 = wr_cnt;
    for (int k = 0; k < 8; k++) do_op(1, 32'h10000 + 32'(k) * 32'h1000, 32'hC0DE_0000 + 32'(k), 4'hF, r);
    chk("R7 invalid ways first", wr_cnt - wr0, 0);
    do_op(1, 32'h18000, 32'hC0DE_0008, 4'hF, r);
    chk("R7 ninth evicts", wr_cnt - wr0, 1);
    chk("R7 plru victim", 32'(wb_log[wr0 % 64]), 32'h400);
    do_op(0, 32'h10000, 0, 0, r);
    chk("R7 evicted data", r, 32'hC0DE_0000);
  endtask

  task automatic t_drain;
    do_op(5, 0, 0, 0, r);
    do_op(1, 32'h0000_0148, 32'hD0D0_0004, 4'hF, r);
    do_op(1, 32'h0000_0040, 32'hE0E0_0002, 4'hF, r);
    do_op(1, 32'h0000_2000, 32'hF0F0_0001, 4'hF, r);
    do_op(1, 32'h0000_3040, 32'h6060_0003, 4'hF, r);
    do_op(0, 32'h0000_4080, 0, 0, r);
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_op(4, 0, 0, 0, r);
    chk("R3 count", wr_cnt - wr0, 4);
    chk("R3 no reads", rd_cnt - rd0, 0);
    chk("R3 order 0", 32'(wb_log[(wr0 + 0) % 64]), 32'h80);
    chk("R3 order 1", 32'(wb_log[(wr0 + 1) % 64]), 32'h1);
    chk("R3 order 2", 32'(wb_log[(wr0 + 2) % 64]), 32'hC1);
    chk("R3 order 3", 32'(wb_log[(wr0 + 3) % 64]), 32'h5);
    do_op(0, 32'h0000_3040, 0, 0, r);
    chk("R3 memory value", r, 32'h6060_0003);
    do_op(0, 32'h0000_4080, 0, 0, r);
    chk("R3 all invalid", rd_cnt - rd0, 2);
  endtask

  task automatic t_busy;
    do_op(1, 32'h5000, 32'h5555_0005, 4'hF, r);
    do_op(1, 32'h6000, 32'h6666_0006, 4'hF, r);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4; req_addr = 0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_op = 3'd1; req_addr = 32'h7004; req_wdata = 32'hABCD_0007; req_wstrb = 4'hF;
    while (!done) @(negedge clk);
    chk("R8 held store not started", rd_cnt - rd0, 0);
    chk("R8 drain finished", wr_cnt - wr0, 2);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 0);
    chk("R8 accepted after drain", 32'(busy), 1);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    do_op(0, 32'h7004, 0, 0, r);
    chk("R8 held store result", r, 32'hABCD_0007);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store_load();
    t_flush();
    t_clean();
    t_discard();
    t_conflict();
    t_drain();
    t_busy();
    chk("R9 request held", hold_viol, 0);
    chk("R9 stalls exercised", 32'(stall_seen > 0), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule